// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block keeps the fuse pattern of a small programmable logic device and decides who may see and change it. A programmer reaches the pattern through an addressed port of byte-wide words, one strobe per cycle, marked as either a read or a write. Three command inputs act on the whole store. One erases every cell and releases the lock. One sets the security lock. One closes the current programming session. The full pattern is always presented on a wide configuration output that feeds the logic array, and a single permit line tells the test logic whether register preload is allowed.

Programming needs no separate erase step. The first write after reset, after an erase or after a closed session wipes the whole pattern and then stores its word. Later writes in the same session can only clear bits. Once the lock is set, every read returns the erased value, preload is refused, and writes are dropped with an error pulse. Only a full erase clears the lock. Reset clears the session and the port registers. It leaves the pattern and the lock as they were, so they act as non-volatile state.

Top module: `cfg_secure_store`

## Requirements
- R1: An erased cell reads as 1; the store powers up fully erased; one cycle after `cmd_erase` is sampled high, every bit of `cfg_vector` is 1.
- R2: The first accepted write of a session leaves every word of `cfg_vector` at 8'hFF except the addressed word, which equals the write data, one cycle after the strobe. Word i occupies bits [8i+7:8i].
- R3: A later write in the same open session sets the addressed word to the AND of its old value and the write data, and leaves the other words unchanged.
- R4: `cmd_done` closes the session, so the next accepted write performs the whole-pattern erase of R2 again.
- R5: A read strobe (`acc_valid` high, `acc_write` low) gives `rd_valid` high and the stored word on `rd_data` one cycle later while unlocked; `rd_valid` is low otherwise.
- R6: After `cmd_secure` the lock is set, and every read returns 8'hFF whatever is stored.
- R7: `preload_ok` is low while the lock is set and high while it is clear.
- R8: A write strobe while locked changes no stored bit, and `wr_err` is high for exactly the following cycle; `wr_err` stays low for writes that are accepted.
- R9: The lock is cleared only by `cmd_erase`; neither `cmd_done` nor reset clears it.
- R10: Reset leaves `cfg_vector` unchanged and closes the session, so the first write after reset erases the whole pattern.
- R11: When `cmd_erase` arrives in the same cycle as `cmd_secure` or a write, the erase wins: the pattern ends fully erased and the lock ends clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of session and port registers |
| acc_valid | input | 1 | Access strobe, one per cycle |
| acc_write | input | 1 | 1 = write, 0 = read for the current strobe |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | DW | Write data; 0 bits program cells |
| cmd_erase | input | 1 | Erase whole pattern and clear lock |
| cmd_secure | input | 1 | Set the security lock |
| cmd_done | input | 1 | Close the programming session |
| rd_data | output | DW | Read result, masked to all ones while locked |
| rd_valid | output | 1 | Read result valid |
| wr_err | output | 1 | One-cycle pulse after a write refused by the lock |
| cfg_vector | output | WORDS*DW | Active configuration pattern |
| preload_ok | output | 1 | Register preload permitted |

## Verification
On every cycle the assertions check that the lock rises only after a secure command and falls only after an erase. They also check that an erase leaves the pattern all ones, that a refused write leaves the pattern stable and raises the error, and that locked reads come back as all ones. What only the directed scenarios can show is the ordering inside a session: the automatic erase on the first write, bit-clearing on later writes, and the reopening after a done command or a reset. The same holds for the survival of pattern and lock across reset and for the erase winning over a same-cycle secure or write.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

   typedef enum logic {
      SESS_IDLE = 1'b0,
      SESS_OPEN = 1'b1
   } sess_e;

   typedef struct packed {
      logic erase;
      logic secure;
      logic done;
   } cmd_t;

endpackage

// File: rtl/cfgs_lock.sv
module cfgs_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic erase_i,
   input  logic secure_i,
   output logic locked_o,
   output logic preload_ok_o
);

   // Non-volatile latch: power-up value only, never touched by rst_n.
   logic lock_q = 1'b0;

   always_ff @(posedge clk) begin
      if (erase_i)
         lock_q <= 1'b0;
      else if (secure_i)
         lock_q <= 1'b1;
   end

   assign locked_o     = lock_q;
   assign preload_ok_o = ~lock_q;

   // R6
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(secure_i));

   // R9
   lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_o) |-> $past(erase_i));

endmodule

// File: rtl/cfgs_array.sv
module cfgs_array
   import cfgs_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int DW    = 8,
   localparam int ADDR_W = $clog2(WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  erase_i,
   input  logic                  done_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     wr_addr_i,
   input  logic [DW-1:0]         wr_data_i,
   output logic [WORDS*DW-1:0]   pat_o
);

   sess_e sess_q;
   logic  fresh;

   // Session state is volatile: reset, erase and done all close it.
   always_ff @(posedge clk) begin
      if (!rst_n)
         sess_q <= SESS_IDLE;
      else if (erase_i || done_i)
         sess_q <= SESS_IDLE;
      else if (wr_en_i)
         sess_q <= SESS_OPEN;
   end

   assign fresh = (sess_q == SESS_IDLE);

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      logic [DW-1:0] word_q = '1;
      logic          hit;

      assign hit = (wr_addr_i == ADDR_W'(gi));

      always_ff @(posedge clk) begin
         if (erase_i)
            word_q <= '1;
         else if (wr_en_i) begin
            if (fresh)
               word_q <= hit ? wr_data_i : '1;
            else if (hit)
               word_q <= word_q & wr_data_i;
         end
      end

      assign pat_o[gi*DW +: DW] = word_q;
   end

   // R1
   erase_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_i |=> (pat_o == '1));

   // R3
   open_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!erase_i && !fresh) |=> ((pat_o & ~$past(pat_o)) == '0));

endmodule

// File: rtl/cfgs_rdport.sv
module cfgs_rdport #(
   parameter int WORDS    = 16,
   parameter int DW       = 8,
   parameter int READ_LAT = 1,
   localparam int ADDR_W  = $clog2(WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   input  logic                  locked_i,
   input  logic [WORDS*DW-1:0]   pat_i,
   output logic [DW-1:0]         rd_data_o,
   output logic                  rd_valid_o
);

   logic [DW-1:0] sel_word;
   logic [DW-1:0] masked;

   assign sel_word = pat_i[rd_addr_i*DW +: DW];
   assign masked   = locked_i ? {DW{1'b1}} : sel_word;

   if (READ_LAT == 1) begin : g_reg
      logic [DW-1:0] data_q;
      logic          valid_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= rd_en_i;
            if (rd_en_i)
               data_q <= masked;
         end
      end

      assign rd_data_o  = data_q;
      assign rd_valid_o = valid_q;

      // R6
      locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en_i && locked_i) |=> (rd_valid_o && rd_data_o == {DW{1'b1}}));
   end else begin : g_comb
      assign rd_data_o  = masked;
      assign rd_valid_o = rd_en_i;

      // R6
      locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en_i && locked_i) |-> (rd_data_o == {DW{1'b1}}));
   end

   if (READ_LAT != 0 && READ_LAT != 1) begin : g_bad_lat
      $error("cfgs_rdport: READ_LAT must be 0 or 1");
   end

endmodule

// File: rtl/cfg_secure_store.sv
module cfg_secure_store
   import cfgs_pkg::*;
#(
   parameter int WORDS    = 16,
   parameter int DW       = 8,
   parameter int READ_LAT = 1,
   localparam int ADDR_W  = $clog2(WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [DW-1:0]         acc_wdata,
   input  logic                  cmd_erase,
   input  logic                  cmd_secure,
   input  logic                  cmd_done,
   output logic [DW-1:0]         rd_data,
   output logic                  rd_valid,
   output logic                  wr_err,
   output logic [WORDS*DW-1:0]   cfg_vector,
   output logic                  preload_ok
);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("cfg_secure_store: WORDS must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("cfg_secure_store: DW must be positive");
   end

   cmd_t cmd;
   logic wr_req, rd_req, wr_en, locked;
   logic err_q;

   assign cmd    = '{erase: cmd_erase, secure: cmd_secure, done: cmd_done};
   assign wr_req = acc_valid &  acc_write;
   assign rd_req = acc_valid & ~acc_write;
   assign wr_en  = wr_req & ~locked & ~cmd.erase;

   cfgs_lock u_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .erase_i      (cmd.erase),
      .secure_i     (cmd.secure),
      .locked_o     (locked),
      .preload_ok_o (preload_ok)
   );

   cfgs_array #(.WORDS(WORDS), .DW(DW)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_i   (cmd.erase),
      .done_i    (cmd.done),
      .wr_en_i   (wr_en),
      .wr_addr_i (acc_addr),
      .wr_data_i (acc_wdata),
      .pat_o     (cfg_vector)
   );

   cfgs_rdport #(.WORDS(WORDS), .DW(DW), .READ_LAT(READ_LAT)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en_i    (rd_req),
      .rd_addr_i  (acc_addr),
      .locked_i   (locked),
      .pat_i      (cfg_vector),
      .rd_data_o  (rd_data),
      .rd_valid_o (rd_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= wr_req & locked;
   end

   assign wr_err = err_q;

   // R8
   refused_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && locked) |=> wr_err);

   // R8
   refused_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && locked && !cmd_erase) |=> $stable(cfg_vector));

   // R7
   preload_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_secure && !cmd_erase) |=> !preload_ok);

   // R11
   erase_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_erase |=> (preload_ok && cfg_vector == '1));

endmodule

// File: tb/cfg_secure_store_tb.sv
module cfg_secure_store_tb;

   localparam int WORDS = 16;
   localparam int DW    = 8;
   localparam int VW    = WORDS * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic          acc_write = 1'b0;
   logic [3:0]    acc_addr = '0;
   logic [7:0]    acc_wdata = '0;
   logic          cmd_erase = 1'b0;
   logic          cmd_secure = 1'b0;
   logic          cmd_done = 1'b0;
   logic [7:0]    rd_data;
   logic          rd_valid;
   logic          wr_err;
   logic [VW-1:0] cfg_vector;
   logic          preload_ok;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   cfg_secure_store u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .cmd_erase(cmd_erase),
      .cmd_secure(cmd_secure), .cmd_done(cmd_done), .rd_data(rd_data),
      .rd_valid(rd_valid), .wr_err(wr_err), .cfg_vector(cfg_vector),
      .preload_ok(preload_ok)
   );

   task automatic chk(input string req, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] with_word(input logic [VW-1:0] v,
                                               input int idx, input logic [7:0] w);
      logic [VW-1:0] r;
      r = v;
      r[idx*8 +: 8] = w;
      return r;
   endfunction

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] q, output logic v);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      @(negedge clk);
      q = rd_data; v = rd_valid;
      acc_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   logic [VW-1:0] exp_v;

   task automatic t_reset_state();
      chk("R1", "power-up pattern", cfg_vector, '1);
      chk("R7", "preload after power-up", VW'(preload_ok), VW'(1));
      chk("R5", "rd_valid idle", VW'(rd_valid), VW'(0));
      chk("R8", "wr_err idle", VW'(wr_err), VW'(0));
   endtask

   task automatic t_session();
      logic [7:0] q; logic v;
      wr(4'd3, 8'h5A);
      exp_v = with_word('1, 3, 8'h5A);
      chk("R2", "first write erases and stores", cfg_vector, exp_v);
      chk("R8", "no error on accepted write", VW'(wr_err), VW'(0));
      wr(4'd3, 8'h0F);
      exp_v = with_word(exp_v, 3, 8'h0A);
      chk("R3", "second write ANDs", cfg_vector, exp_v);
      wr(4'd7, 8'h33);
      exp_v = with_word(exp_v, 7, 8'h33);
      chk("R3", "other word kept in session", cfg_vector, exp_v);
      rd(4'd3, q, v);
      chk("R5", "read data unlocked", VW'(q), VW'(8'h0A));
      chk("R5", "read valid", VW'(v), VW'(1));
      @(negedge clk);
      chk("R5", "rd_valid drops", VW'(rd_valid), VW'(0));
   endtask

   task automatic t_done_reopens();
      cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
      chk("R4", "done keeps pattern", cfg_vector, exp_v);
      wr(4'd1, 8'hC3);
      exp_v = with_word('1, 1, 8'hC3);
      chk("R4", "write after done erases", cfg_vector, exp_v);
   endtask

   task automatic t_reset_keeps();
      do_reset();
      chk("R10", "pattern kept over reset", cfg_vector, exp_v);
      wr(4'd2, 8'h11);
      exp_v = with_word('1, 2, 8'h11);
      chk("R10", "first write after reset erases", cfg_vector, exp_v);
   endtask

   task automatic t_lock();
      logic [7:0] q; logic v;
      cmd_secure = 1'b1; @(negedge clk); cmd_secure = 1'b0;
      chk("R7", "preload blocked when locked", VW'(preload_ok), VW'(0));
      chk("R6", "pattern still active", cfg_vector, exp_v);
      rd(4'd2, q, v);
      chk("R6", "locked read masked", VW'(q), VW'(8'hFF));
      wr(4'd2, 8'h00);
      chk("R8", "locked write ignored", cfg_vector, exp_v);
      chk("R8", "wr_err pulse", VW'(wr_err), VW'(1));
      @(negedge clk);
      chk("R8", "wr_err one cycle", VW'(wr_err), VW'(0));
      wr(4'd5, 8'h00);
      chk("R8", "locked write other word ignored", cfg_vector, exp_v);
      cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
      chk("R9", "done keeps lock", VW'(preload_ok), VW'(0));
      do_reset();
      chk("R9", "reset keeps lock", VW'(preload_ok), VW'(0));
      rd(4'd2, q, v);
      chk("R9", "locked read after reset", VW'(q), VW'(8'hFF));
   endtask

   task automatic t_erase_priority();
      logic [7:0] q; logic v;
      cmd_erase = 1'b1; cmd_secure = 1'b1;
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd4; acc_wdata = 8'h00;
      @(negedge clk);
      cmd_erase = 1'b0; cmd_secure = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
      chk("R11", "erase wins over write", cfg_vector, '1);
      chk("R11", "erase wins over secure", VW'(preload_ok), VW'(1));
      rd(4'd2, q, v);
      chk("R1", "erased word reads ones", VW'(q), VW'(8'hFF));
      wr(4'd0, 8'h80);
      chk("R8", "write accepted after erase", cfg_vector, with_word('1, 0, 8'h80));
      chk("R8", "no error after erase", VW'(wr_err), VW'(0));
      rd(4'd0, q, v);
      chk("R5", "read back after unlock", VW'(q), VW'(8'h80));
      cmd_secure = 1'b1; @(negedge clk); cmd_secure = 1'b0;
      cmd_erase = 1'b1; @(negedge clk); cmd_erase = 1'b0;
      chk("R9", "erase alone clears lock", VW'(preload_ok), VW'(1));
      chk("R1", "erase clears pattern", cfg_vector, '1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_session();
      t_done_reopens();
      t_reset_keeps();
      t_lock();
      t_erase_priority();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule